// File: doc/BRIEF.md
# SDRAM Burst-Write Command Sequencer

This block is the write path of a synchronous DRAM controller. It accepts one request to write a full 32-byte line, for example a cache-line copy-back or a 32-byte DMA transfer, over a 32-bit data path. It then drives the SDRAM pins through a fixed sequence:

1. A row-open command.
2. A write command carrying auto-precharge, issued in the very next cycle.
3. Eight consecutive data beats.
4. A programmable write-recovery wait.
5. A programmable precharge wait.

While the sequence runs, the block holds a busy indication, and it refuses further requests until the bank may be reopened.

The eight words go out in wrapped order. The first word is the one the request names. The order then continues to the end of the aligned eight-word line and wraps back to the line start. The write data is pulled from the requester one word at a time. A pull strobe and a word index ask for each word one cycle before that word appears on the data pins.

Top module: `sdram_burst_wr`

## Requirements
- R1: After reset the block is idle with `req_ready_o`=1, `busy_o`=0, `cs_n_o`=`ras_n_o`=`cas_n_o`=`we_n_o`=1, `dqm_o`=4'hF, `dq_oe_o`=0 and `cke_o`=1.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. In the next cycle the block drives the row-open command: `cs_n_o`=0, `ras_n_o`=0, `cas_n_o`=1, `we_n_o`=1. In that same cycle `addr_o` equals the requested row and `ba_o` equals the requested bank.
- R3: The cycle directly after the row-open command carries the write command: `cs_n_o`=0, `ras_n_o`=1, `cas_n_o`=0, `we_n_o`=0. In that cycle `addr_o[10]`=1 selects auto-precharge, and `addr_o[8:0]` holds the requested column with its low three bits equal to the start word.
- R4: Eight data beats are driven on `dq_o` in consecutive cycles, starting with the write-command cycle. Beat k carries word ((s+k) mod 8) of the line, where s is the requested column's low three bits. During beats 1 to 7, `addr_o[8:0]` shows the column of that beat and `addr_o[10]`=0.
- R5: `data_pull_o` is 1 in the row-open cycle and during beats 0 to 6, and 0 otherwise. When it is 1, `data_idx_o` names the word for the following beat, and the `wr_data_i` value in that cycle is the word driven in the next cycle.
- R6: `dqm_o`=4'h0 and `dq_oe_o`=1 during the eight data beats. `dqm_o`=4'hF and `dq_oe_o`=0 in every other cycle.
- R7: After the last beat, a recovery wait of n+1 cycles follows, where n is the value of `recov_cfg_i` captured at acceptance (0 to 7).
- R8: A precharge wait of m+1 cycles follows the recovery wait, where m is the value of `pchg_cfg_i` captured at acceptance (0 to 3).
- R9: `busy_o`=1 and `req_ready_o`=0 from the row-open cycle to the end of the precharge wait. The total is 1+8+(n+1)+(m+1) cycles. A request presented during that time is ignored, and no row-open command appears before the block is idle again.
- R10: During beats 1 to 7 and during both waits, the command pins encode no-operation: `cs_n_o`=0, `ras_n_o`=`cas_n_o`=`we_n_o`=1.
- R11: `cke_o` is 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Line write request |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_bank_i | input | 2 | Bank of the request |
| req_row_i | input | 13 | Row address |
| req_col_i | input | 9 | Column of the first word (low 3 bits = start word) |
| recov_cfg_i | input | 3 | Write-recovery setting n (n+1 cycles) |
| pchg_cfg_i | input | 2 | Precharge-wait setting m (m+1 cycles) |
| data_pull_o | output | 1 | Requests the next write word |
| data_idx_o | output | 3 | Word index within the line being pulled |
| wr_data_i | input | 32 | Write word, sampled while pull is high |
| busy_o | output | 1 | Bank in use until the precharge wait ends |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Row or column address, bit 10 = auto-precharge |
| dqm_o | output | 4 | Byte masks |
| dq_o | output | 32 | Write data |
| dq_oe_o | output | 1 | Data output enable |

## Verification
The hardest case to reach from the ports is a request that arrives while the bank is still recovering or precharging. The block must ignore that request and accept it only once it is idle again. To reach it, the stimulus keeps a second request asserted, with a different row and bank, for the whole wait. It checks that every wait cycle shows a no-operation command and a low ready. It then confirms that ready rises only after exactly (n+1)+(m+1) wait cycles. The wrapped beat order is covered by running all eight start words. The wait lengths are covered by sweeping all eight recovery settings and all four precharge settings.

// File: rtl/sdram_bw_pkg.sv
package sdram_bw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_BURST = 3'd2,
    ST_RECOV = 3'd3,
    ST_PCHG  = 3'd4
  } bw_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_ACT   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_bw_wrap.sv
// Column of a word inside an aligned line, offset from a start word with wraparound.
module sdram_bw_wrap #(
  parameter int COL_W = 9,
  parameter int OFS_W = 3
) (
  input  logic [COL_W-1:0] base_col_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic [OFS_W-1:0] word_o,
  output logic [COL_W-1:0] col_o
);
  logic [OFS_W-1:0] word;

  always_comb begin
    word   = base_col_i[OFS_W-1:0] + offset_i;
    word_o = word;
    col_o  = {base_col_i[COL_W-1:OFS_W], word};
  end
endmodule

// File: rtl/sdram_bw_ctrl.sv
module sdram_bw_ctrl
  import sdram_bw_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int BEATS    = 8,
  parameter int RECOV_W  = 3,
  parameter int PCHG_W   = 2,
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int WAIT_W  = (RECOV_W > PCHG_W) ? RECOV_W : PCHG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [RECOV_W-1:0] recov_cfg_i,
  input  logic [PCHG_W-1:0] pchg_cfg_i,
  output bw_state_e         state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              pull_o,
  output logic [BEAT_W-1:0] pull_ofs_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  bw_state_e         state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [RECOV_W-1:0] recov_q;
  logic [PCHG_W-1:0] pchg_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_ACT;
      ST_ACT: begin
        state_d = ST_BURST;
        beat_d  = '0;
      end
      ST_BURST: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == LAST_BEAT) begin
          state_d = ST_RECOV;
          wait_d  = WAIT_W'(recov_q);
        end
      end
      ST_RECOV: begin
        if (wait_q == '0) begin
          state_d = ST_PCHG;
          wait_d  = WAIT_W'(pchg_q);
        end else begin
          wait_d = wait_q - 1'b1;
        end
      end
      ST_PCHG: begin
        if (wait_q == '0) state_d = ST_IDLE;
        else              wait_d  = wait_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      wait_q  <= wait_d;
    end
  end

  // request fields are held for the whole sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      recov_q <= '0;
      pchg_q  <= '0;
    end else if (accept) begin
      bank_q  <= req_bank_i;
      row_q   <= req_row_i;
      col_q   <= req_col_i;
      recov_q <= recov_cfg_i;
      pchg_q  <= pchg_cfg_i;
    end
  end

  always_comb begin
    pull_o     = (state_q == ST_ACT) || ((state_q == ST_BURST) && (beat_q != LAST_BEAT));
    pull_ofs_o = (state_q == ST_ACT) ? '0 : beat_q + 1'b1;
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
endmodule

// File: rtl/sdram_bw_pins.sv
module sdram_bw_pins
  import sdram_bw_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 13,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 32,
  parameter int AP_BIT  = 10,
  parameter int BEAT_W  = 3,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bw_state_e         state_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  beat_col_i,
  input  logic              pull_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MASK_W-1:0] dqm_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  sd_cmd_t           cmd;
  logic [DATA_W-1:0] dq_q;
  logic              beat_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dq_q <= '0;
    else if (pull_i) dq_q <= wr_data_i;
  end

  assign beat_act = (state_i == ST_BURST);

  always_comb begin
    cmd    = CMD_DESEL;
    addr_o = '0;
    ba_o   = bank_i;
    unique case (state_i)
      ST_IDLE: ba_o = '0;
      ST_ACT: begin
        cmd    = CMD_ACT;
        addr_o = ADDR_W'(row_i);
      end
      ST_BURST: begin
        cmd                = (beat_i == '0) ? CMD_WRITE : CMD_NOP;
        addr_o[COL_W-1:0]  = beat_col_i;
        addr_o[AP_BIT]     = (beat_i == '0);
      end
      ST_RECOV, ST_PCHG: cmd = CMD_NOP;
      default: cmd = CMD_DESEL;
    endcase
  end

  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign dqm_o   = beat_act ? '0 : '1;
  assign dq_oe_o = beat_act;
  assign dq_o    = dq_q;
endmodule

// File: rtl/sdram_burst_wr.sv
module sdram_burst_wr
  import sdram_bw_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 32,
  parameter int BEATS   = 8,
  parameter int RECOV_W = 3,
  parameter int PCHG_W  = 2,
  parameter int AP_BIT  = 10,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int MASK_W = DATA_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic [ADDR_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  logic [RECOV_W-1:0] recov_cfg_i,
  input  logic [PCHG_W-1:0]  pchg_cfg_i,
  output logic               data_pull_o,
  output logic [BEAT_W-1:0]  data_idx_o,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               busy_o,
  output logic               cke_o,
  output logic               cs_n_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic [BANK_W-1:0]  ba_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [MASK_W-1:0]  dqm_o,
  output logic [DATA_W-1:0]  dq_o,
  output logic               dq_oe_o
);
  bw_state_e         state;
  logic [BEAT_W-1:0] beat, pull_ofs, beat_word;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] row;
  logic [COL_W-1:0]  col, beat_col, pull_col;
  logic              pull;

  sdram_bw_ctrl #(
    .BANK_W (BANK_W),
    .ROW_W  (ADDR_W),
    .COL_W  (COL_W),
    .BEATS  (BEATS),
    .RECOV_W(RECOV_W),
    .PCHG_W (PCHG_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_bank_i (req_bank_i),
    .req_row_i  (req_row_i),
    .req_col_i  (req_col_i),
    .recov_cfg_i(recov_cfg_i),
    .pchg_cfg_i (pchg_cfg_i),
    .state_o    (state),
    .beat_o     (beat),
    .bank_o     (bank),
    .row_o      (row),
    .col_o      (col),
    .pull_o     (pull),
    .pull_ofs_o (pull_ofs)
  );

  // column on the pins for the current beat
  sdram_bw_wrap #(.COL_W(COL_W), .OFS_W(BEAT_W)) u_wrap_beat (
    .base_col_i(col),
    .offset_i  (beat),
    .word_o    (beat_word),
    .col_o     (beat_col)
  );

  // word requested from the source one cycle ahead
  sdram_bw_wrap #(.COL_W(COL_W), .OFS_W(BEAT_W)) u_wrap_pull (
    .base_col_i(col),
    .offset_i  (pull_ofs),
    .word_o    (data_idx_o),
    .col_o     (pull_col)
  );

  sdram_bw_pins #(
    .BANK_W(BANK_W),
    .ADDR_W(ADDR_W),
    .ROW_W (ADDR_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .AP_BIT(AP_BIT),
    .BEAT_W(BEAT_W)
  ) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .beat_i    (beat),
    .bank_i    (bank),
    .row_i     (row),
    .beat_col_i(beat_col),
    .pull_i    (pull),
    .wr_data_i (wr_data_i),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .ba_o      (ba_o),
    .addr_o    (addr_o),
    .dqm_o     (dqm_o),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );

  logic unused_ok;
  assign unused_ok   = ^{beat_word, pull_col};
  assign data_pull_o = pull;
  assign busy_o      = (state != ST_IDLE);
  assign req_ready_o = (state == ST_IDLE);
  assign cke_o       = 1'b1;
endmodule

// File: rtl/sdram_burst_wr_chk.sv
module sdram_burst_wr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        busy_o,
  input logic        data_pull_o,
  input logic        cs_n_o,
  input logic        ras_n_o,
  input logic        cas_n_o,
  input logic        we_n_o,
  input logic [12:0] addr_o,
  input logic [3:0]  dqm_o,
  input logic        dq_oe_o,
  input logic        cke_o
);
  logic act_cmd, wr_cmd;
  assign act_cmd = !cs_n_o && !ras_n_o && cas_n_o && we_n_o;
  assign wr_cmd  = !cs_n_o && ras_n_o && !cas_n_o && !we_n_o;

  // R2
  accept_opens_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> act_cmd);

  // R3
  write_follows_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_cmd |=> (wr_cmd && addr_o[10]));

  // R5
  pull_leads_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_pull_o |=> dq_oe_o);

  // R6
  mask_tracks_beats_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o ? (dqm_o == 4'h0) : (dqm_o == 4'hF));

  // R9
  no_accept_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  // R11
  clock_enable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o);
endmodule

bind sdram_burst_wr sdram_burst_wr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .busy_o     (busy_o),
  .data_pull_o(data_pull_o),
  .cs_n_o     (cs_n_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .addr_o     (addr_o),
  .dqm_o      (dqm_o),
  .dq_oe_o    (dq_oe_o),
  .cke_o      (cke_o)
);

// File: tb/sdram_burst_wr_bench.sv
`timescale 1ns/1ps
module sdram_burst_wr_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_bank_i = '0;
  logic [12:0] req_row_i = '0;
  logic [8:0]  req_col_i = '0;
  logic [2:0]  recov_cfg_i = '0;
  logic [1:0]  pchg_cfg_i = '0;
  logic        data_pull_o;
  logic [2:0]  data_idx_o;
  logic [31:0] wr_data_i;
  logic        busy_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dq_oe_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;
  logic [3:0]  dqm_o;
  logic [31:0] dq_o;

  logic [7:0]  tag = 8'h00;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #4 clk_i = ~clk_i;

  // source supplies a word marked by tag and line index
  assign wr_data_i = {tag, 21'd0, data_idx_o};

  sdram_burst_wr u_sdram_burst_wr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_bank_i(req_bank_i), .req_row_i(req_row_i), .req_col_i(req_col_i),
    .recov_cfg_i(recov_cfg_i), .pchg_cfg_i(pchg_cfg_i),
    .data_pull_o(data_pull_o), .data_idx_o(data_idx_o), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .dqm_o(dqm_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      finish_sim();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd_pins();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic test_reset();
    @(negedge clk_i);
    chk(req_ready_o && !busy_o, "R1 idle", {req_ready_o, busy_o}, 2'b10);
    chk(cmd_pins() == 4'hF, "R1 pins", cmd_pins(), 4'hF);
    chk(dqm_o == 4'hF && !dq_oe_o, "R1 dqm", {dqm_o, dq_oe_o}, 5'h1E);
    chk(cke_o, "R11 cke", cke_o, 1);
  endtask

  // one full line write; hold_next keeps a second request pending throughout
  task automatic run_burst(input logic [1:0] bank, input logic [12:0] row, input logic [8:0] col,
                           input logic [2:0] n, input logic [1:0] m, input bit hold_next,
                           input string wait_req);
    int waits;
    logic [2:0] s;
    s = col[2:0];
    @(negedge clk_i);
    tag = tag + 8'd1;
    req_bank_i = bank; req_row_i = row; req_col_i = col;
    recov_cfg_i = n; pchg_cfg_i = m; req_valid_i = 1'b1;
    chk(req_ready_o, "R9 ready before", req_ready_o, 1);
    @(negedge clk_i);
    if (hold_next) begin
      req_bank_i = ~bank; req_row_i = ~row; recov_cfg_i = 3'd7; pchg_cfg_i = 2'd3;
    end else begin
      req_valid_i = 1'b0;
    end
    chk(cmd_pins() == 4'b0011, "R2 act cmd", cmd_pins(), 4'b0011);
    chk(addr_o == row && ba_o == bank, "R2 row/bank", {ba_o, addr_o}, {bank, row});
    chk(busy_o && !req_ready_o, "R9 busy", {busy_o, req_ready_o}, 2'b10);
    chk(data_pull_o && data_idx_o == s, "R5 pull act", {data_pull_o, data_idx_o}, {1'b1, s});
    chk(dqm_o == 4'hF && !dq_oe_o, "R6 mask act", dqm_o, 4'hF);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] w, nx;
      @(negedge clk_i);
      w  = s + 3'(k);
      nx = s + 3'(k + 1);
      if (k == 0) begin
        chk(cmd_pins() == 4'b0100, "R3 write cmd", cmd_pins(), 4'b0100);
        chk(addr_o[10] && addr_o[8:0] == col, "R3 col/ap", addr_o, {4'b0010, col});
      end else begin
        chk(cmd_pins() == 4'b0111, "R10 nop beat", cmd_pins(), 4'b0111);
        chk(!addr_o[10] && addr_o[8:0] == {col[8:3], w}, "R4 beat col", addr_o, {col[8:3], w});
      end
      chk(dq_o == {tag, 21'd0, w}, "R4 data order", dq_o, {tag, 21'd0, w});
      chk(dqm_o == 4'h0 && dq_oe_o, "R6 mask beat", {dqm_o, dq_oe_o}, 5'h01);
      if (k < 7)
        chk(data_pull_o && data_idx_o == nx, "R5 pull beat", {data_pull_o, data_idx_o}, {1'b1, nx});
      else
        chk(!data_pull_o, "R5 pull end", data_pull_o, 0);
      chk(busy_o && !req_ready_o, "R9 busy beat", {busy_o, req_ready_o}, 2'b10);
    end
    waits = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk_i);
      if (!busy_o) break;
      waits++;
      chk(cmd_pins() == 4'b0111, "R10 nop wait", cmd_pins(), 4'b0111);
      chk(dqm_o == 4'hF && !dq_oe_o && !data_pull_o && !req_ready_o, "R9 wait quiet",
          {dqm_o, dq_oe_o, data_pull_o, req_ready_o}, 7'h78);
    end
    chk(waits == int'(n) + int'(m) + 2, wait_req, waits, int'(n) + int'(m) + 2);
    chk(req_ready_o && cmd_pins() == 4'hF, "R9 idle after", {req_ready_o, cmd_pins()}, 5'h1F);
    chk(cke_o, "R11 cke", cke_o, 1);
    req_valid_i = 1'b0;
  endtask

  task automatic test_wrap_all_starts();
    for (int s = 0; s < 8; s++)
      run_burst(2'(s), 13'h0A5 + 13'(s), {6'h2C, 3'(s)}, 3'd0, 2'd0, 1'b0, "R7 wait wrap");
  endtask

  task automatic test_recovery_all();
    for (int n = 0; n < 8; n++)
      run_burst(2'd1, 13'h1F00, 9'h105, 3'(n), 2'd1, 1'b0, "R7 recovery len");
  endtask

  task automatic test_precharge_all();
    for (int m = 0; m < 4; m++)
      run_burst(2'd2, 13'h0333, 9'h0F3, 3'd2, 2'(m), 1'b0, "R8 precharge len");
  endtask

  task automatic test_refuse_while_busy();
    run_burst(2'd3, 13'h1ABC, 9'h1FE, 3'd5, 2'd3, 1'b1, "R9 held req wait");
    run_burst(2'd0, 13'h0001, 9'h007, 3'd7, 2'd2, 1'b1, "R9 held req wait");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_wrap_all_starts();
    test_recovery_all();
    test_precharge_all();
    test_refuse_while_busy();
    repeat (2) @(negedge clk_i);
    finish_sim();
  end
endmodule